// File: doc/BRIEF.md
# Posted Write Target Acceptor

This block is the receiving front end of a bus bridge. It sits on the initiator side of a parallel PCI bus. When an initiator starts a memory write burst whose address falls inside a programmed forwarding window, the block claims the transaction and takes the data at full bus rate. It places the address and every data word into a posted write queue, so the initiator never waits for the far bus. A separate delivery engine, not part of this block, drains the queue.

The block answers with medium decode timing. It takes one DWORD per clock and ends the burst early with a disconnect-with-data in two cases. The first is when the data address reaches a boundary that depends on the command: a cache line for write-and-invalidate, an aligned 4 KB page for plain memory write. The second is when the queue space it measured at claim time is used up. A burst that arrives with too little queue space is retried and leaves nothing in the queue.

Top module: `posted_write_acceptor`

## Requirements
- R1: While reset is held and after it is released, `devsel_n`, `trdy_n` and `stop_n` are high and `q_push` is low until a transaction is claimed.
- R2: A burst is considered only when the command nibble on `cbe_n` in the address phase is 4'b0111 (memory write) or 4'b1111 (memory write and invalidate), the address has bits [1:0] equal to 0, and the address lies between `win_base` and `win_limit` inclusive. Any other burst never drives `devsel_n` low and queues nothing.
- R3: Number the address-phase clock as cycle 1. A claimed or retried burst drives `devsel_n` low from cycle 3, which is medium decode. A claimed burst drives `trdy_n` low from cycle 4, one cycle after `devsel_n`.
- R4: A burst is claimed only if `q_free` is at least 2 in cycle 2. The address entry is pushed in cycle 3 with `q_is_addr`=1, `q_payload`=address, `q_be`=the raw command nibble and `q_last`=0.
- R5: Once claimed, `trdy_n` stays low every cycle with no wait state until the burst ends. Every clock edge with `irdy_n` and `trdy_n` both low pushes one data entry in the next cycle: `q_is_addr`=0, `q_payload`=`ad`, and `q_be` equal to the bitwise inverse of `cbe_n`.
- R6: A data phase transferred with `frame_n` high is the final one. Its entry has `q_last`=1, and all three target outputs are high in the next cycle.
- R7: With write-and-invalidate, the data phase whose DWORD index modulo `line_dw` equals `line_dw`-1 is the last accepted (`line_dw` is a power of two). With memory write, the last accepted phase is the one whose DWORD index modulo 1024 equals 1023. That phase asserts `stop_n` together with `trdy_n`, and its entry has `q_last`=1.
- R8: The data credit is `q_free`-1, sampled in cycle 2. The phase that uses the last credit disconnects with data, as in R7. When the credit and the boundary end on the same phase, exactly one disconnect occurs.
- R9: After a disconnect with data while `frame_n` is still low, `trdy_n` goes high and `devsel_n` and `stop_n` stay low until a clock edge samples `frame_n` high. In the following cycle all three outputs are high.
- R10: A burst that passes R2 but not the space check of R4 is retried. `devsel_n` and `stop_n` go low, `trdy_n` stays high, nothing is queued, and the retry holds until a clock edge samples `frame_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Address in the address phase, write data in data phases |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| devsel_n | output | 1 | Target claims the transaction, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target requests the end of the transaction, active low |
| win_base | input | 32 | Lowest forwarded byte address |
| win_limit | input | 32 | Highest forwarded byte address |
| line_dw | input | 8 | Cache line size in DWORDs, a power of two |
| q_free | input | 8 | Free entries in the posted write queue |
| q_push | output | 1 | Queue write strobe |
| q_is_addr | output | 1 | Entry is an address entry |
| q_payload | output | 32 | Entry address or data |
| q_be | output | 4 | Data byte enables, or command nibble for an address entry |
| q_last | output | 1 | Final data entry of the burst |

## Verification
Two limits on acceptance can act on the same data phase: the command-dependent address boundary and the exhaustion of queue credit. A write-and-invalidate burst starts two DWORDs before a line end, with exactly three free queue entries. The boundary and the credit then both fall on the second phase. The bench expects one disconnect with data there, two queued data entries with the last flag on the second, and a clean release afterwards. A related case puts the initiator's own final phase on a line end. That phase must carry both the stop and the last flag, and the burst must end at once without a hold phase.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

    localparam int DATA_W   = 32;
    localparam int CMD_W    = 4;
    localparam int PAGE_LOG = 10;

    localparam logic [CMD_W-1:0] CMD_MEM_WRITE     = 4'b0111;
    localparam logic [CMD_W-1:0] CMD_MEM_WRITE_INV = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CLAIM,
        ST_DATA,
        ST_HOLD,
        ST_RETRY
    } tgt_state_e;

    typedef struct packed {
        logic              is_addr;
        logic [DATA_W-1:0] payload;
        logic [CMD_W-1:0]  be;
        logic              last;
    } q_entry_t;

    function automatic logic is_posted_cmd(input logic [CMD_W-1:0] c);
        return (c == CMD_MEM_WRITE) || (c == CMD_MEM_WRITE_INV);
    endfunction

    function automatic logic at_page_end(input logic [DATA_W-3:0] dw);
        return &dw[PAGE_LOG-1:0];
    endfunction

endpackage

// File: rtl/pwa_decode.sv
module pwa_decode
    import pwa_pkg::*;
#(
    parameter int FREE_W = 8
) (
    input  logic [DATA_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] win_base,
    input  logic [DATA_W-1:0] win_limit,
    input  logic [FREE_W-1:0] q_free,
    output logic              hit,
    output logic              room
);
    localparam logic [FREE_W-1:0] MIN_ROOM = FREE_W'(2);

    logic in_window;

    always_comb begin
        in_window = (addr >= win_base) && (addr <= win_limit);
        hit       = is_posted_cmd(cmd) && (addr[1:0] == 2'b00) && in_window;
        room      = (q_free >= MIN_ROOM);
    end
endmodule

// File: rtl/pwa_burst.sv
module pwa_burst
    import pwa_pkg::*;
#(
    parameter int FREE_W = 8,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [DATA_W-3:0] start_dw,
    input  logic              is_mwi,
    input  logic [LINE_W-1:0] line_dw,
    input  logic [FREE_W-1:0] free_in,
    output logic              final_phase
);
    logic [DATA_W-3:0] dw_q;
    logic [FREE_W-1:0] credit_q;
    logic              mwi_q;
    logic [LINE_W-1:0] line_mask;
    logic              line_end;
    logic              credit_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            dw_q     <= '0;
            credit_q <= '0;
            mwi_q    <= 1'b0;
        end else if (load) begin
            dw_q     <= start_dw;
            credit_q <= free_in - FREE_W'(1);
            mwi_q    <= is_mwi;
        end else if (advance) begin
            dw_q     <= dw_q + 1'b1;
            credit_q <= credit_q - FREE_W'(1);
        end
    end

    always_comb begin
        line_mask   = line_dw - LINE_W'(1);
        line_end    = (dw_q[LINE_W-1:0] & line_mask) == line_mask;
        credit_end  = (credit_q == FREE_W'(1));
        final_phase = credit_end || (mwi_q ? line_end : at_page_end(dw_q));
    end
endmodule

// File: rtl/pwa_qwrite.sv
module pwa_qwrite
    import pwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push_addr,
    input  logic              push_data,
    input  logic [DATA_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] ad,
    input  logic [CMD_W-1:0]  cbe_n,
    input  logic              last,
    output logic              push,
    output q_entry_t          entry
);
    q_entry_t next_entry;

    always_comb begin
        next_entry = '0;
        if (push_addr) begin
            next_entry.is_addr = 1'b1;
            next_entry.payload = addr;
            next_entry.be      = cmd;
        end else begin
            next_entry.payload = ad;
            next_entry.be      = ~cbe_n;
            next_entry.last    = last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push  <= 1'b0;
            entry <= '0;
        end else begin
            push <= push_addr || push_data;
            if (push_addr || push_data) begin
                entry <= next_entry;
            end
        end
    end
endmodule

// File: rtl/posted_write_acceptor.sv
module posted_write_acceptor
    import pwa_pkg::*;
#(
    parameter int FREE_W = 8,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [DATA_W-1:0] ad,
    input  logic [CMD_W-1:0]  cbe_n,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    input  logic [DATA_W-1:0] win_base,
    input  logic [DATA_W-1:0] win_limit,
    input  logic [LINE_W-1:0] line_dw,
    input  logic [FREE_W-1:0] q_free,
    output logic              q_push,
    output logic              q_is_addr,
    output logic [DATA_W-1:0] q_payload,
    output logic [CMD_W-1:0]  q_be,
    output logic              q_last
);
    tgt_state_e        state_q;
    tgt_state_e        state_d;
    logic              frame_prev_q;
    logic [DATA_W-1:0] addr_q;
    logic [CMD_W-1:0]  cmd_q;
    logic              hit;
    logic              room;
    logic              final_phase;
    logic              addr_phase;
    logic              claim;
    logic              xfer;
    logic              xfer_last;
    q_entry_t          entry;

    pwa_decode #(.FREE_W(FREE_W)) u_decode (
        .addr      (addr_q),
        .cmd       (cmd_q),
        .win_base  (win_base),
        .win_limit (win_limit),
        .q_free    (q_free),
        .hit       (hit),
        .room      (room)
    );

    pwa_burst #(.FREE_W(FREE_W), .LINE_W(LINE_W)) u_burst (
        .clk         (clk),
        .rst         (rst),
        .load        (claim),
        .advance     (xfer),
        .start_dw    (addr_q[DATA_W-1:2]),
        .is_mwi      (cmd_q == CMD_MEM_WRITE_INV),
        .line_dw     (line_dw),
        .free_in     (q_free),
        .final_phase (final_phase)
    );

    pwa_qwrite u_qwrite (
        .clk       (clk),
        .rst       (rst),
        .push_addr (claim),
        .push_data (xfer),
        .addr      (addr_q),
        .cmd       (cmd_q),
        .ad        (ad),
        .cbe_n     (cbe_n),
        .last      (xfer_last),
        .push      (q_push),
        .entry     (entry)
    );

    always_comb begin
        addr_phase = (state_q == ST_IDLE) && !frame_n && frame_prev_q;
        claim      = (state_q == ST_DECODE) && hit && room;
        xfer       = (state_q == ST_DATA) && !irdy_n;
        xfer_last  = frame_n || final_phase;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (addr_phase) state_d = ST_DECODE;
            ST_DECODE: begin
                if (claim)    state_d = ST_CLAIM;
                else if (hit) state_d = ST_RETRY;
                else          state_d = ST_IDLE;
            end
            ST_CLAIM:  state_d = ST_DATA;
            ST_DATA: begin
                if (xfer) begin
                    if (frame_n)          state_d = ST_IDLE;
                    else if (final_phase) state_d = ST_HOLD;
                end
            end
            ST_HOLD:   if (frame_n) state_d = ST_IDLE;
            ST_RETRY:  if (frame_n) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            frame_prev_q <= 1'b1;
            addr_q       <= '0;
            cmd_q        <= '0;
        end else begin
            state_q      <= state_d;
            frame_prev_q <= frame_n;
            if (addr_phase) begin
                addr_q <= ad;
                cmd_q  <= cbe_n;
            end
        end
    end

    always_comb begin
        devsel_n  = !((state_q == ST_CLAIM) || (state_q == ST_DATA) ||
                      (state_q == ST_HOLD)  || (state_q == ST_RETRY));
        trdy_n    = !(state_q == ST_DATA);
        stop_n    = !(((state_q == ST_DATA) && final_phase) ||
                      (state_q == ST_HOLD) || (state_q == ST_RETRY));
        q_is_addr = entry.is_addr;
        q_payload = entry.payload;
        q_be      = entry.be;
        q_last    = entry.last;
    end

    // R3: a claim (devsel falling without stop) is followed by trdy
    p_trdy_after_devsel_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(devsel_n) && stop_n) |=> !trdy_n);

    // R4 and R10: the address entry appears exactly when the claim is not a retry
    p_claim_pushes_addr_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> ((q_push && q_is_addr) == stop_n));

    // R5: a data entry only follows a completed data phase
    p_data_needs_xfer_r5: assert property (@(posedge clk) disable iff (rst)
        (q_push && !q_is_addr) |-> $past(!irdy_n && !trdy_n));

    // R7: a data phase taken under stop is flagged as the last entry
    p_last_on_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (q_push && !q_is_addr && $past(!stop_n)) |-> q_last);

    // R9: stop is held while the initiator keeps the frame asserted
    p_stop_held_r9: assert property (@(posedge clk) disable iff (rst)
        (!stop_n && !frame_n) |=> !stop_n);

endmodule

// File: tb/posted_write_acceptor_test.sv
module posted_write_acceptor_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        devsel_n, trdy_n, stop_n;
    logic [31:0] win_base = 32'h1000_0000;
    logic [31:0] win_limit = 32'h1FFF_FFFF;
    logic [7:0]  line_dw = 8'd8;
    logic [7:0]  q_free = 8'd16;
    logic        q_push, q_is_addr, q_last;
    logic [31:0] q_payload;
    logic [3:0]  q_be;

    int n_tests = 0;
    int n_fail  = 0;
    logic [37:0] exp_q[$];

    always #10 clk = ~clk;

    posted_write_acceptor uut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
        .cbe_n(cbe_n), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .win_base(win_base), .win_limit(win_limit), .line_dw(line_dw),
        .q_free(q_free), .q_push(q_push), .q_is_addr(q_is_addr),
        .q_payload(q_payload), .q_be(q_be), .q_last(q_last)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dval(input int seed, input int i);
        return 32'hA500_0000 | (32'(seed) << 8) | 32'(i);
    endfunction

    // Scoreboard monitor: entries R4 (address), R5/R6/R7/R8 (data and last flag)
    always @(negedge clk) begin
        if (!rst && q_push) begin
            if (exp_q.size() == 0) begin
                chk("R2/R10 unexpected queue push", 1, 0);
            end else begin
                logic [37:0] e;
                e = exp_q.pop_front();
                chk(e[37] ? "R4 address entry" : "R5/R6/R7/R8 data entry",
                    {26'd0, q_is_addr, q_payload, q_be, q_last}, {26'd0, e});
            end
        end
    end

    task automatic burst(input logic [31:0] a, input logic [3:0] cmd, input int n,
                         input int free, input int seed, input string tag);
        bit hit, room, fr, ending, done, stop_td, retry_seen;
        int credit, tob, lim, exp_acc, dw, cls, acc, i, c, first_dev, first_trdy, waits;
        logic s_dev, s_trdy, s_stop;
        hit  = (cmd == 4'b0111 || cmd == 4'b1111) && a[1:0] == 2'b00 &&
               a >= win_base && a <= win_limit;
        room = free >= 2;
        exp_acc = 0; lim = n + 1;
        if (hit && room) begin
            credit = free - 1;
            dw  = int'(a >> 2);
            cls = int'(line_dw);
            tob = (cmd == 4'b1111) ? cls - (dw % cls) : 1024 - (dw % 1024);
            lim = (credit < tob) ? credit : tob;
            exp_acc = (n < lim) ? n : lim;
            exp_q.push_back({1'b1, a, cmd, 1'b0});
            for (int k = 0; k < exp_acc; k++)
                exp_q.push_back({1'b0, dval(seed, k), ~4'(k), k == exp_acc - 1});
        end
        acc = 0; i = 0; ending = 0; done = 0; stop_td = 0; retry_seen = 0;
        first_dev = 0; first_trdy = 0; waits = 0;
        @(negedge clk);
        q_free = 8'(free); frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = cmd;
        @(negedge clk);
        fr = (n == 1); frame_n = fr; irdy_n = 1'b0; ad = dval(seed, 0); cbe_n = 4'(0);
        s_dev = devsel_n; s_trdy = trdy_n; s_stop = stop_n;
        if (!s_dev) first_dev = 1;
        c = 2;
        while (!done && c < 60) begin
            @(negedge clk);
            if (!s_trdy) begin
                acc++;
                if (!s_stop) stop_td = 1;
            end
            if (ending) begin
                irdy_n = 1'b1; frame_n = 1'b1; done = 1;
            end else if (!s_trdy) begin
                i++;
                if (fr) begin
                    irdy_n = 1'b1; done = 1;
                end else if (!s_stop) begin
                    frame_n = 1'b1; fr = 1; ending = 1;
                end else begin
                    ad = dval(seed, i); cbe_n = 4'(i); fr = (i == n - 1); frame_n = fr;
                end
            end else if (!s_stop) begin
                retry_seen = 1;
                if (fr) begin irdy_n = 1'b1; done = 1; end
                else begin frame_n = 1'b1; fr = 1; ending = 1; end
            end else if (s_dev && c >= 6) begin
                frame_n = 1'b1; irdy_n = 1'b1; done = 1;
            end else if (!s_dev && first_trdy != 0) begin
                waits++;
            end
            s_dev = devsel_n; s_trdy = trdy_n; s_stop = stop_n;
            if (!s_dev && first_dev == 0) first_dev = c;
            if (!s_trdy && first_trdy == 0) first_trdy = c;
            if (ending && !done)
                chk({tag, " R9/R10 hold phase"}, {s_dev, s_trdy, s_stop}, 3'b010);
            c++;
        end
        chk({tag, " R6/R9 release"}, {devsel_n, trdy_n, stop_n}, 3'b111);
        chk({tag, " R2/R3 devsel cycle"}, 64'(first_dev), hit ? 64'd2 : 64'd0);
        chk({tag, " R3 trdy cycle"}, 64'(first_trdy), (hit && room) ? 64'd3 : 64'd0);
        chk({tag, " R5/R7/R8 accepted count"}, 64'(acc), 64'(exp_acc));
        chk({tag, " R7/R8 disconnect with data"}, 64'(stop_td), 64'(hit && room && lim <= n));
        chk({tag, " R10 retry"}, 64'(retry_seen), 64'(hit && !room));
        chk({tag, " R5 wait states"}, 64'(waits), 64'd0);
        @(negedge clk); @(negedge clk);
        chk({tag, " R4/R10 queue drained"}, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {devsel_n, trdy_n, stop_n, q_push}, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", {devsel_n, trdy_n, stop_n, q_push}, 4'b1110);

        burst(32'h1000_0100, 4'b0111, 1, 8, 1, "single MW");
        burst(32'h1000_0200, 4'b0111, 4, 16, 2, "burst MW");
        burst(32'h1000_0014, 4'b1111, 6, 16, 3, "R7 MWI line");
        burst(32'h1000_0FF8, 4'b0111, 5, 16, 4, "R7 MW page");
        burst(32'h1000_001C, 4'b0111, 4, 16, 5, "R7 MW ignores line");
        burst(32'h1000_0300, 4'b0111, 5, 3, 6, "R8 full");
        burst(32'h1000_0018, 4'b1111, 5, 3, 7, "R8 full and line together");
        burst(32'h1000_0018, 4'b1111, 2, 16, 8, "R6 end on line");
        burst(32'h1000_0400, 4'b0111, 3, 2, 9, "R8 one credit");
        burst(32'h1000_0500, 4'b0111, 3, 1, 10, "R10 retry");
        burst(32'h1000_0600, 4'b1111, 1, 0, 11, "R10 retry single");
        burst(32'h1000_0700, 4'b0110, 3, 16, 12, "R2 read cmd");
        burst(32'h1000_0704, 4'b0011, 2, 16, 13, "R2 io cmd");
        burst(32'h2000_0000, 4'b0111, 2, 16, 14, "R2 outside window");
        burst(32'h1000_0802, 4'b0111, 2, 16, 15, "R2 misaligned");
        line_dw = 8'd4;
        burst(32'h1000_0004, 4'b1111, 8, 16, 16, "R7 MWI short line");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule